// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one command byte from a host to a PS/2 keyboard and collects the keyboard's one-byte reply. The clock and data wires are open-drain. The block never drives them high. It only asserts a pull-down enable per wire and senses the resulting line level. A transfer begins with a `start` strobe that carries the command byte. The block first inhibits the bus by holding the clock low. It then asserts the start bit on the data wire and hands the clock back to the device. Each frame bit is placed after a device clock falling edge. After the frame, the block watches for the device's line-level acknowledge, then receives an 11-bit response frame and judges it.

A transfer succeeds only when a well-formed response frame carries 0xFA. Any other outcome releases both wires and starts a fresh attempt, up to a parameterised number of attempts in total. The outcomes that fail are:
- a different byte,
- a bad start, stop or parity bit,
- an expired wait.

When the keyboard answers with a valid 0xFE (resend), the next attempt waits through a back-off period first. The command sequencer above the block sees a one-cycle `done` pulse, the last received byte, and two flags: `ok` for success and `timed_out` when the final attempt ended on an expired wait.

The controller has twelve states:
- **IDLE**: waits for `start`.
- **INHIBIT**: holds the clock low.
- **STARTBIT**: one cycle with both wires low.
- **HANDOFF**: clock released, data still low, waits for the clock to read high.
- **SEND**: clocks out data, parity and stop bits.
- **ACK_LO** and **ACK_HI**: wait for the device to pull data low and then release it.
- **CLK_REL**: waits for the clock to be high.
- **RECV**: shifts in 11 response bits.
- **EVAL**: judges the response.
- **BACKOFF**: the resend delay.
- **RELEASE**: a one-cycle gap before the next attempt.

The transitions are:
- IDLE→INHIBIT on `start`.
- INHIBIT→STARTBIT when the inhibit time expires.
- STARTBIT→HANDOFF.
- HANDOFF→SEND once the clock reads high.
- SEND→ACK_LO on the rising edge after the stop bit.
- ACK_LO→ACK_HI→CLK_REL→RECV.
- RECV→EVAL after 11 bits.
- EVAL→IDLE on success or after the last attempt.
- EVAL→BACKOFF on a valid resend.
- EVAL→RELEASE otherwise.
- Any waiting state goes to RELEASE, or to IDLE on the last attempt, when its timeout expires.
- RELEASE→INHIBIT.
- BACKOFF→INHIBIT when the back-off expires.

Top module: `ps2_cmd_xmit`

## Requirements
- R1: After reset both pull-down enables are low, and `done`, `ok`, `timed_out` and `resp` are all zero.
- R2: On `start` the clock pull-down is held for at least INHIBIT_CYC cycles. The data pull-down is already asserted when the clock pull-down is removed, which forms the start bit.
- R3: The eight command bits go out least significant bit first. Each bit is placed after a falling edge of the device clock and is stable at the following rising edge.
- R4: The data bits are followed by an odd parity bit (data plus parity hold an odd number of ones) and then a stop bit of 1. The data wire is left released after the stop bit.
- R5: After the acknowledge, the block captures an 11-bit response frame on device clock falling edges: start bit 0, eight data bits least significant bit first, odd parity, stop bit 1. The data byte appears on `resp` at `done`.
- R6: When the response frame is well formed and its byte is 0xFA, `done` pulses for one cycle with `ok`=1 and `timed_out`=0, and no further attempt is made.
- R7: Any other response byte starts a new attempt. At most MAX_TRIES attempts are made in total. After the last failed one, `done` pulses with `ok`=0 and `resp` holding the last byte.
- R8: After a well-formed 0xFE response, the next attempt's clock inhibit begins no sooner than BACKOFF_CYC cycles later. After any other failure, the next attempt begins within a few cycles.
- R9: Each waiting phase is bounded by TIMEOUT_CYC cycles. With a silent device, MAX_TRIES attempts are made, then `done` pulses with `ok`=0 and `timed_out`=1.
- R10: A `start` strobe or a `cmd` change while a transfer is in progress has no effect: the device receives the original command and `done` pulses only once.
- R11: A response frame whose parity bit is wrong counts as a failed attempt, even when its data byte is 0xFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a transfer when idle |
| cmd | input | 8 | Command byte, captured with `start` |
| ps2_clk_in | input | 1 | Sensed level of the PS/2 clock wire |
| ps2_dat_in | input | 1 | Sensed level of the PS/2 data wire |
| ps2_clk_pull | output | 1 | 1 pulls the clock wire low, 0 releases it |
| ps2_dat_pull | output | 1 | 1 pulls the data wire low, 0 releases it |
| done | output | 1 | One-cycle pulse when the transfer ends |
| resp | output | 8 | Last response byte received |
| ok | output | 1 | Transfer ended with a valid 0xFA reply |
| timed_out | output | 1 | Final attempt ended on an expired wait |

## Verification
The bench uses a behavioural keyboard model. The model clocks the frame in, checks every data, parity and stop bit, acknowledges, and answers with a chosen reply byte whose parity it can corrupt.

The bench targets these corner cases:
- **Resend back-off.** A design that skipped the resend delay would start the next inhibit a few cycles after the reply, and the measured gap exposes it.
- **Corrupted parity on a 0xFA reply.** A design that ignored the parity check would report success on the first attempt.
- **Exhausted retries and a silent device.** An off-by-one attempt counter shows up as four or six inhibits instead of five. A stuck wait shows up as no `done` at all.
- **A second `start` mid-transfer.** This would re-capture the command or restart the sequence.

// File: rtl/ps2x_pkg.sv
package ps2x_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INHIBIT,
        ST_STARTBIT,
        ST_HANDOFF,
        ST_SEND,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_CLK_REL,
        ST_RECV,
        ST_EVAL,
        ST_BACKOFF,
        ST_RELEASE
    } xstate_e;

    // data(8) + parity + stop driven by the host
    localparam logic [3:0] TX_BITS  = 4'd10;
    // start + data(8) + parity + stop sent by the device
    localparam logic [3:0] RX_BITS  = 4'd11;
    localparam logic [7:0] ACK_BYTE = 8'hFA;
    localparam logic [7:0] RESEND   = 8'hFE;

endpackage

// File: rtl/ps2x_sync.sv
module ps2x_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] sync
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign sync[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ps2x_edge.sv
module ps2x_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = prev & ~lvl;

endmodule

// File: rtl/ps2x_timer.sv
module ps2x_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/ps2_cmd_xmit.sv
module ps2_cmd_xmit
    import ps2x_pkg::*;
#(
    parameter int INHIBIT_CYC = 41500,
    parameter int TIMEOUT_CYC = 2048000,
    parameter int BACKOFF_CYC = 8250000,
    parameter int MAX_TRIES   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] cmd,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       ps2_clk_pull,
    output logic       ps2_dat_pull,
    output logic       done,
    output logic [7:0] resp,
    output logic       ok,
    output logic       timed_out
);

    localparam int TMAX1 = (INHIBIT_CYC > TIMEOUT_CYC) ? INHIBIT_CYC : TIMEOUT_CYC;
    localparam int TMAX  = (TMAX1 > BACKOFF_CYC) ? TMAX1 : BACKOFF_CYC;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int AW    = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

    // ---------------- line conditioning ----------------
    logic [1:0] lines_s;
    logic       s_clk, s_dat, clk_rise, clk_fall;

    ps2x_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({ps2_dat_in, ps2_clk_in}),
        .sync  (lines_s)
    );
    assign s_clk = lines_s[0];
    assign s_dat = lines_s[1];

    ps2x_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (s_clk),
        .rise  (clk_rise),
        .fall  (clk_fall)
    );

    // ---------------- shared phase timer ----------------
    xstate_e       st_q, st_d;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;

    assign tmr_load = (st_d != st_q);

    always_comb begin
        unique case (st_d)
            ST_INHIBIT: tmr_val = TW'(INHIBIT_CYC - 1);
            ST_BACKOFF: tmr_val = TW'(BACKOFF_CYC - 1);
            default:    tmr_val = TW'(TIMEOUT_CYC - 1);
        endcase
    end

    ps2x_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // ---------------- datapath registers ----------------
    logic [7:0]    cmd_q;
    logic [3:0]    bidx;
    logic          tx_low;
    logic          tx_bit;
    logic [10:0]   rx_sh;
    logic [3:0]    rcnt;
    logic [AW-1:0] att_q;
    logic          done_q, ok_q, tout_q;
    logic [7:0]    resp_q;

    logic [7:0] rx_byte;
    logic       frame_ok, last_try, reply_ack, reply_resend;
    xstate_e    fail_st;

    assign rx_byte      = rx_sh[8:1];
    assign frame_ok     = ~rx_sh[0] & rx_sh[10] & (^rx_sh[9:1]);
    assign last_try     = (att_q == AW'(MAX_TRIES - 1));
    assign reply_ack    = frame_ok && (rx_byte == ACK_BYTE);
    assign reply_resend = frame_ok && (rx_byte == RESEND);
    assign fail_st      = last_try ? ST_IDLE : ST_RELEASE;

    always_comb begin
        if (bidx < 4'd8)      tx_bit = cmd_q[bidx[2:0]];
        else if (bidx == 4'd8) tx_bit = ~^cmd_q;
        else                  tx_bit = 1'b1;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (start) st_d = ST_INHIBIT;
            ST_INHIBIT:  if (tmr_exp) st_d = ST_STARTBIT;
            ST_STARTBIT: st_d = ST_HANDOFF;
            ST_HANDOFF: begin
                if (s_clk)        st_d = ST_SEND;
                else if (tmr_exp) st_d = fail_st;
            end
            ST_SEND: begin
                if (clk_rise && bidx == TX_BITS) st_d = ST_ACK_LO;
                else if (tmr_exp)                st_d = fail_st;
            end
            ST_ACK_LO: begin
                if (!s_dat)       st_d = ST_ACK_HI;
                else if (tmr_exp) st_d = fail_st;
            end
            ST_ACK_HI: begin
                if (s_dat)        st_d = ST_CLK_REL;
                else if (tmr_exp) st_d = fail_st;
            end
            ST_CLK_REL: begin
                if (s_clk)        st_d = ST_RECV;
                else if (tmr_exp) st_d = fail_st;
            end
            ST_RECV: begin
                if (rcnt == RX_BITS) st_d = ST_EVAL;
                else if (tmr_exp)    st_d = fail_st;
            end
            ST_EVAL: begin
                if (reply_ack || last_try) st_d = ST_IDLE;
                else if (reply_resend)     st_d = ST_BACKOFF;
                else                       st_d = ST_RELEASE;
            end
            ST_BACKOFF:  if (tmr_exp) st_d = ST_INHIBIT;
            ST_RELEASE:  st_d = ST_INHIBIT;
            default:     st_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            bidx   <= '0;
            tx_low <= 1'b0;
            rx_sh  <= '0;
            rcnt   <= '0;
            att_q  <= '0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            tout_q <= 1'b0;
            resp_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    cmd_q  <= cmd;
                    att_q  <= '0;
                    ok_q   <= 1'b0;
                    tout_q <= 1'b0;
                end
                ST_HANDOFF: begin
                    bidx   <= '0;
                    tx_low <= 1'b1;
                end
                ST_SEND: if (clk_fall && bidx < TX_BITS) begin
                    tx_low <= ~tx_bit;
                    bidx   <= bidx + 4'd1;
                end
                ST_CLK_REL: rcnt <= '0;
                ST_RECV: if (clk_fall) begin
                    rx_sh <= {s_dat, rx_sh[10:1]};
                    rcnt  <= rcnt + 4'd1;
                end
                ST_EVAL: resp_q <= rx_byte;
                default: ;
            endcase
            if (st_q != ST_IDLE && st_d == ST_IDLE) begin
                done_q <= 1'b1;
                ok_q   <= (st_q == ST_EVAL) && reply_ack;
                tout_q <= (st_q != ST_EVAL);
            end
            if ((st_d == ST_RELEASE || st_d == ST_BACKOFF) && st_d != st_q)
                att_q <= att_q + AW'(1);
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ps2_clk_pull = (st_q == ST_INHIBIT) || (st_q == ST_STARTBIT);
        ps2_dat_pull = (st_q == ST_STARTBIT) || (st_q == ST_HANDOFF) ||
                       ((st_q == ST_SEND) && tx_low);
    end

    assign done      = done_q;
    assign ok        = ok_q;
    assign timed_out = tout_q;
    assign resp      = resp_q;

    // ---------------- assertions ----------------
    a_r2_start_bit_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps2_clk_pull) |-> ps2_dat_pull);

    a_r6_ok_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (resp == ACK_BYTE));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(ok && timed_out));

    a_r1_lines_free_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ps2_clk_pull && !ps2_dat_pull));

    a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(cmd_q));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r7_try_bound: assert (int'(att_q) < MAX_TRIES);
        end
    end

endmodule

// File: tb/ps2_cmd_xmit_tb.sv
`timescale 1ns/1ps
module ps2_cmd_xmit_tb;

    localparam int INH   = 40;
    localparam int TMO   = 400;
    localparam int BOF   = 600;
    localparam int TRIES = 5;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] r1;
        logic       bad1;
        logic [3:0] n1;
        logic [7:0] r2;
        logic       exp_ok;
        logic [3:0] exp_att;
        logic [7:0] exp_resp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'hED, 8'hFA, 1'b0, 4'd0, 8'hFA, 1'b1, 4'd1, 8'hFA},
        '{8'hF2, 8'hFE, 1'b0, 4'd1, 8'hFA, 1'b1, 4'd2, 8'hFA},
        '{8'h00, 8'hFA, 1'b1, 4'd1, 8'hFA, 1'b1, 4'd2, 8'hFA},
        '{8'h55, 8'h00, 1'b0, 4'd5, 8'h00, 1'b0, 4'd5, 8'h00},
        '{8'h80, 8'hFE, 1'b0, 4'd5, 8'hFE, 1'b0, 4'd5, 8'hFE},
        '{8'hFF, 8'h12, 1'b0, 4'd2, 8'hFA, 1'b1, 4'd3, 8'hFA}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cmd_in = 8'h00;
    logic       dev_clk = 1'b1;
    logic       dev_dat = 1'b1;
    logic       clk_pull, dat_pull, done, ok, timed_out;
    logic [7:0] resp;
    wire        line_clk = dev_clk & ~clk_pull;
    wire        line_dat = dev_dat & ~dat_pull;

    always #2 clk = ~clk;

    ps2_cmd_xmit #(
        .INHIBIT_CYC (INH),
        .TIMEOUT_CYC (TMO),
        .BACKOFF_CYC (BOF),
        .MAX_TRIES   (TRIES)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cmd          (cmd_in),
        .ps2_clk_in   (line_clk),
        .ps2_dat_in   (line_dat),
        .ps2_clk_pull (clk_pull),
        .ps2_dat_pull (dat_pull),
        .done         (done),
        .resp         (resp),
        .ok           (ok),
        .timed_out    (timed_out)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    bit wd_hit = 0;
    bit summary_done = 0;

    // observation state
    int         n_inh, n_done, short_inh, bad_start, tx_bad, max_gap, inh_t0, resp_end;
    bit         done_seen, cap_ok, cap_to, prev_pull;
    logic [7:0] cap_resp, exp_cmd, got_tx;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (done) begin
            n_done++;
            done_seen = 1;
            cap_ok    = ok;
            cap_to    = timed_out;
            cap_resp  = resp;
        end
        if (clk_pull && !prev_pull) begin
            n_inh++;
            inh_t0 = cyc;
            if (cyc - resp_end > max_gap) max_gap = cyc - resp_end;
        end
        if (!clk_pull && prev_pull) begin
            if (cyc - inh_t0 < INH) short_inh++;
            if (!dat_pull) bad_start++;
        end
        prev_pull = clk_pull;
    end

    // keyboard model: one attempt, entered while the host inhibits
    task automatic dev_attempt(input logic [7:0] rb, input bit bad, input bit silent);
        logic [9:0]  bits;
        logic [10:0] rf;
        while (clk_pull) @(negedge clk);
        if (!silent) begin
            repeat (4) @(negedge clk);
            for (int i = 0; i < 10; i++) begin
                dev_clk = 1'b0;
                repeat (8) @(negedge clk);
                bits[i] = line_dat;
                dev_clk = 1'b1;
                repeat (8) @(negedge clk);
            end
            got_tx = bits[7:0];
            if (bits[7:0] !== exp_cmd || bits[8] !== ~^exp_cmd || bits[9] !== 1'b1) tx_bad++;
            repeat (4) @(negedge clk);
            if (line_dat !== 1'b1) tx_bad++;
            dev_dat = 1'b0;
            repeat (4) @(negedge clk);
            dev_clk = 1'b0;
            repeat (8) @(negedge clk);
            dev_clk = 1'b1;
            repeat (8) @(negedge clk);
            dev_dat = 1'b1;
            repeat (20) @(negedge clk);
            rf = {1'b1, (~^rb) ^ bad, rb, 1'b0};
            for (int i = 0; i < 11; i++) begin
                dev_dat = rf[i];
                repeat (4) @(negedge clk);
                dev_clk = 1'b0;
                if (i == 10) resp_end = cyc;
                repeat (8) @(negedge clk);
                dev_clk = 1'b1;
                repeat (4) @(negedge clk);
            end
            dev_dat = 1'b1;
        end
    endtask

    task automatic run_xfer(input logic [7:0] c, input logic [7:0] r1, input bit b1,
                            input int n1, input logic [7:0] r2, input bit silent);
        int k = 0;
        exp_cmd = c; got_tx = 8'h00;
        n_inh = 0; n_done = 0; done_seen = 0; short_inh = 0; bad_start = 0;
        tx_bad = 0; max_gap = 0; resp_end = cyc;
        start = 1'b1; cmd_in = c;
        @(negedge clk);
        start = 1'b0;
        while (!done_seen && !wd_hit) begin
            if (clk_pull) begin
                dev_attempt((k < n1) ? r1 : r2, (k < n1) ? b1 : 1'b0, silent);
                k++;
            end else begin
                @(negedge clk);
            end
        end
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 clk_pull", clk_pull, 0);
        check("R1 dat_pull", dat_pull, 0);
        check("R1 done", done, 0);
        check("R1 ok", ok, 0);
        check("R1 timed_out", timed_out, 0);
        check("R1 resp", resp, 0);

        for (int v = 0; v < NV; v++) begin
            run_xfer(VECS[v].cmd, VECS[v].r1, VECS[v].bad1, int'(VECS[v].n1), VECS[v].r2, 1'b0);
            check("R6 ok", cap_ok, VECS[v].exp_ok);
            check("R5 resp", cap_resp, VECS[v].exp_resp);
            check("R9 timed_out low", cap_to, 0);
            check("R7 attempts", n_inh, VECS[v].exp_att);
            check("R6 done count", n_done, 1);
            check("R3/R4 frame bits", tx_bad, 0);
            check("R2 inhibit length", short_inh, 0);
            check("R2 start bit", bad_start, 0);
            if (VECS[v].r1 == 8'hFE && VECS[v].n1 != 0)
                check("R8 resend backoff", (max_gap >= BOF), 1);
            else
                check("R8 fast retry", (max_gap < 50), 1);
            if (VECS[v].bad1)
                check("R11 parity fail retried", n_inh, 2);
        end

        // silent device: every attempt times out
        run_xfer(8'hEE, 8'h00, 1'b0, 0, 8'h00, 1'b1);
        check("R9 ok low", cap_ok, 0);
        check("R9 timed_out", cap_to, 1);
        check("R9 attempts", n_inh, TRIES);
        check("R9 done count", n_done, 1);

        // second start and cmd change while busy
        fork
            run_xfer(8'hA5, 8'hFA, 1'b0, 0, 8'hFA, 1'b0);
            begin
                repeat (100) @(negedge clk);
                start = 1'b1; cmd_in = 8'h3C;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (50) @(negedge clk);
        check("R10 device got original", got_tx, 8'hA5);
        check("R10 single attempt", n_inh, 1);
        check("R10 single done", n_done, 1);
        check("R10 ok", cap_ok, 1);

        summary();
        $finish;
    end

endmodule